// File: doc/BRIEF.md
# Load Queue Ordering-Violation Detector

This block keeps a small table of loads that are in flight, each tagged with its program-order sequence number and, once the load has executed, its effective address. A slot is handed out when a load is dispatched. The slot receives the address when the load executes. When the pipeline retires loads up to a given sequence number, or discards loads younger than a given sequence number, the matching slots are released.

Every executing store is compared against the table. A load counts as a conflict if it is the same age as the store or younger, has already executed, and touches the same 256-byte region. The oldest such load is captured as the ordering violator. The store receives a machine-check pulse and a violation counter advances. The captured violator stays until the consumer reads it, and the read clears it. While a violator is waiting to be read, later stores are not searched at all.

The capture logic is a two-state machine. In state REC_EMPTY no violator is held. The transition REC_EMPTY to REC_HELD is taken when a store finds a conflict. In state REC_HELD the violator is presented on the outputs. The transition REC_HELD to REC_EMPTY is taken when the violator is read. A separate flag tracks one blocked load, so that a squash that reaches back past it can release it.

Top module: `lq_order_check`

## Requirements
- R1: `alloc_idx` always shows the lowest-numbered free slot. A load is taken into that slot when `alloc_valid` is high, `lq_full` is low and no squash is requested. `lq_full` is high exactly when every slot is occupied, and an allocation attempted while full changes nothing.
- R2: `exec_valid` with `exec_idx` writes the address of an occupied slot. A load that has not executed carries an invalid-address marker and never matches a store, whatever its stored address bits hold.
- R3: A load matches a store when the load's sequence number is greater than or equal to the store's, and when the load address shifted right by 8 equals the store address shifted right by 8. Loads older than the store are skipped.
- R4: When a store finds one or more matches, the match with the smallest sequence number is captured. On the edge after the store, `viol_valid` is high, `viol_idx`/`viol_seq` give that load, `st_fault` pulses high for one cycle and `viol_count` increases by one.
- R5: While a violator is held, executing stores do not search. They produce no `st_fault`, the counter does not move, and the held violator is unchanged.
- R6: Raising `rd_viol` while `viol_valid` is high returns the violator on the outputs in that cycle and clears `viol_valid` at the next edge. A store in the same cycle as that read is still skipped.
- R7: `commit_valid` with `commit_seq` frees every occupied slot whose sequence number is less than or equal to `commit_seq`.
- R8: `squash_valid` with `squash_seq` frees every occupied slot whose sequence number is greater than `squash_seq`. Freed loads can no longer match.
- R9: `blk_set` records a blocked load with sequence number `blk_seq` and raises `load_blocked`. A squash with `squash_seq` strictly less than that number clears it, and any other squash leaves it set.
- R10: After reset all slots are free, `alloc_idx` is 0, and `lq_full`, `viol_valid`, `st_fault`, `load_blocked` and `viol_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch a load |
| alloc_seq | input | SEQ_W | Sequence number of the dispatched load |
| alloc_idx | output | IDX_W | Slot that the next dispatched load takes |
| lq_full | output | 1 | No free slot |
| exec_valid | input | 1 | A load has executed |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Effective address of the executed load |
| st_valid | input | 1 | A store executes |
| st_seq | input | SEQ_W | Store sequence number |
| st_addr | input | ADDR_W | Store effective address |
| st_fault | output | 1 | Machine-check pulse for the store that found a violator |
| commit_valid | input | 1 | Retire loads |
| commit_seq | input | SEQ_W | Youngest sequence number retired |
| squash_valid | input | 1 | Discard younger loads |
| squash_seq | input | SEQ_W | Last sequence number that survives the squash |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| load_blocked | output | 1 | A blocked load is recorded |
| rd_viol | input | 1 | Read and clear the violator |
| viol_valid | output | 1 | Violator held |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_count | output | CNT_W | Number of violations captured |

## Verification
The store search and the violator read can fall in the same cycle. That is the case where a new conflict could slip in at the moment the old one is cleared. The bench first captures a violator. It then raises `rd_viol` together with a store that would conflict. It checks that the held violator is visible before the edge, that after the edge nothing is held, that `st_fault` stays low and that the counter has not moved. A following store with the same address must then be captured normally, which shows the store was skipped rather than lost to a broken record.

// File: rtl/lq_pkg.sv
package lq_pkg;

    // Violator record states
    typedef enum logic {
        REC_EMPTY = 1'b0,
        REC_HELD  = 1'b1
    } rec_state_e;

endpackage

// File: rtl/lq_free_pick.sv
module lq_free_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] busy,
    output logic [IDX_W-1:0] pick,
    output logic             none_free
);

    // Lowest-numbered free slot wins; scan from the top so the last write sticks.
    always_comb begin
        pick      = '0;
        none_free = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                pick      = IDX_W'(i);
                none_free = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lq_oldest_match.sv
module lq_oldest_match #(
    parameter int DEPTH        = 8,
    parameter int IDX_W        = 3,
    parameter int SEQ_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int REGION_SHIFT = 8
) (
    input  logic [DEPTH-1:0]  slot_busy,
    input  logic [DEPTH-1:0]  slot_addr_ok,
    input  logic [SEQ_W-1:0]  slot_seq  [DEPTH],
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [SEQ_W-1:0]  hit_seq
);

    logic [DEPTH-1:0]  cand;
    logic [ADDR_W-1:0] st_region;

    assign st_region = st_addr >> REGION_SHIFT;

    // Per-slot candidate: executed, same age or younger, same coarse region
    for (genvar g = 0; g < DEPTH; g++) begin : g_cand
        assign cand[g] = slot_busy[g] && slot_addr_ok[g] &&
                         (slot_seq[g] >= st_seq) &&
                         ((slot_addr[g] >> REGION_SHIFT) == st_region);
    end

    // Oldest candidate by sequence number
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_seq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!hit || (slot_seq[i] < hit_seq))) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
                hit_seq = slot_seq[i];
            end
        end
    end

endmodule

// File: rtl/lq_viol_rec.sv
module lq_viol_rec
    import lq_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [SEQ_W-1:0] hit_seq,
    input  logic             rd_viol,
    output logic             viol_valid,
    output logic [IDX_W-1:0] viol_idx,
    output logic [SEQ_W-1:0] viol_seq,
    output logic             st_fault,
    output logic [CNT_W-1:0] viol_count
);

    rec_state_e state_q, state_d;
    logic       capture;

    // Search only runs when nothing is held at the start of the cycle
    assign capture = (state_q == REC_EMPTY) && st_valid && hit;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REC_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REC_EMPTY: if (capture) state_d = REC_HELD;
            REC_HELD:  if (rd_viol) state_d = REC_EMPTY;
            default:   state_d = REC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_fault   <= 1'b0;
            viol_idx   <= '0;
            viol_seq   <= '0;
            viol_count <= '0;
        end else begin
            st_fault <= capture;
            if (capture) begin
                viol_idx   <= hit_idx;
                viol_seq   <= hit_seq;
                viol_count <= viol_count + 1'b1;
            end
        end
    end

    assign viol_valid = (state_q == REC_HELD);

    // R4
    fault_holds_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> viol_valid && (viol_count == $past(viol_count) + 1'b1));

    // R5
    held_no_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !rd_viol) |=> !st_fault && $stable(viol_count) &&
                                     $stable(viol_idx) && viol_valid);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && rd_viol) |=> !viol_valid && !st_fault);

endmodule

// File: rtl/lq_order_check.sv
module lq_order_check #(
    parameter int DEPTH        = 8,
    parameter int SEQ_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int REGION_SHIFT = 8,
    parameter int CNT_W        = 16,
    localparam int IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              lq_full,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              st_fault,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              blk_set,
    input  logic [SEQ_W-1:0]  blk_seq,
    output logic              load_blocked,
    input  logic              rd_viol,
    output logic              viol_valid,
    output logic [IDX_W-1:0]  viol_idx,
    output logic [SEQ_W-1:0]  viol_seq,
    output logic [CNT_W-1:0]  viol_count
);

    logic [DEPTH-1:0]  busy_q;
    logic [DEPTH-1:0]  addr_ok_q;
    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic              alloc_fire;
    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic [SEQ_W-1:0]  m_seq;
    logic [SEQ_W-1:0]  blk_seq_q;

    lq_free_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .busy      (busy_q),
        .pick      (alloc_idx),
        .none_free (lq_full)
    );

    assign alloc_fire = alloc_valid && !lq_full && !squash_valid;

    // Slot storage: allocate, release on commit or squash, address on execute
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic take, drop;
        assign take = alloc_fire && (alloc_idx == IDX_W'(g));
        assign drop = busy_q[g] &&
                      ((commit_valid && (seq_q[g] <= commit_seq)) ||
                       (squash_valid && (seq_q[g] >  squash_seq)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[g]    <= 1'b0;
                addr_ok_q[g] <= 1'b0;
                seq_q[g]     <= '0;
                addr_q[g]    <= '0;
            end else if (take) begin
                busy_q[g]    <= 1'b1;
                addr_ok_q[g] <= 1'b0;
                seq_q[g]     <= alloc_seq;
            end else if (drop) begin
                busy_q[g]    <= 1'b0;
                addr_ok_q[g] <= 1'b0;
            end else if (exec_valid && busy_q[g] && (exec_idx == IDX_W'(g))) begin
                addr_ok_q[g] <= 1'b1;
                addr_q[g]    <= exec_addr;
            end
        end
    end

    lq_oldest_match #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(SEQ_W),
        .ADDR_W(ADDR_W), .REGION_SHIFT(REGION_SHIFT)
    ) u_match (
        .slot_busy    (busy_q),
        .slot_addr_ok (addr_ok_q),
        .slot_seq     (seq_q),
        .slot_addr    (addr_q),
        .st_seq       (st_seq),
        .st_addr      (st_addr),
        .hit          (m_hit),
        .hit_idx      (m_idx),
        .hit_seq      (m_seq)
    );

    lq_viol_rec #(.IDX_W(IDX_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .hit        (m_hit),
        .hit_idx    (m_idx),
        .hit_seq    (m_seq),
        .rd_viol    (rd_viol),
        .viol_valid (viol_valid),
        .viol_idx   (viol_idx),
        .viol_seq   (viol_seq),
        .st_fault   (st_fault),
        .viol_count (viol_count)
    );

    // Blocked-load flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_blocked <= 1'b0;
            blk_seq_q    <= '0;
        end else if (blk_set) begin
            load_blocked <= 1'b1;
            blk_seq_q    <= blk_seq;
        end else if (squash_valid && load_blocked && (squash_seq < blk_seq_q)) begin
            load_blocked <= 1'b0;
        end
    end

    // R1
    alloc_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> busy_q[$past(alloc_idx)] &&
                       (seq_q[$past(alloc_idx)] == $past(alloc_seq)));

    // R9
    blk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !blk_set && load_blocked && (squash_seq < blk_seq_q))
            |=> !load_blocked);

endmodule

// File: tb/lq_order_check_tb.sv
module lq_order_check_tb;

    localparam int DEPTH  = 8;
    localparam int SEQ_W  = 16;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_valid;
    logic [SEQ_W-1:0]  alloc_seq;
    logic [IDX_W-1:0]  alloc_idx;
    logic              lq_full;
    logic              exec_valid;
    logic [IDX_W-1:0]  exec_idx;
    logic [ADDR_W-1:0] exec_addr;
    logic              st_valid;
    logic [SEQ_W-1:0]  st_seq;
    logic [ADDR_W-1:0] st_addr;
    logic              st_fault;
    logic              commit_valid;
    logic [SEQ_W-1:0]  commit_seq;
    logic              squash_valid;
    logic [SEQ_W-1:0]  squash_seq;
    logic              blk_set;
    logic [SEQ_W-1:0]  blk_seq;
    logic              load_blocked;
    logic              rd_viol;
    logic              viol_valid;
    logic [IDX_W-1:0]  viol_idx;
    logic [SEQ_W-1:0]  viol_seq;
    logic [CNT_W-1:0]  viol_count;

    int n_chk = 0;
    int n_err = 0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    lq_order_check #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx), .lq_full(lq_full),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr), .st_fault(st_fault),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .blk_set(blk_set), .blk_seq(blk_seq), .load_blocked(load_blocked),
        .rd_viol(rd_viol), .viol_valid(viol_valid), .viol_idx(viol_idx),
        .viol_seq(viol_seq), .viol_count(viol_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; alloc_seq = '0; exec_valid = 0; exec_idx = '0; exec_addr = '0;
        st_valid = 0; st_seq = '0; st_addr = '0; commit_valid = 0; commit_seq = '0;
        squash_valid = 0; squash_seq = '0; blk_set = 0; blk_seq = '0; rd_viol = 0;
    endtask

    task automatic edge_and_settle();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic do_alloc(input int seq, input int exp_idx, input string req);
        @(negedge clk);
        check(req, 32'(alloc_idx), 32'(exp_idx));
        alloc_valid = 1; alloc_seq = SEQ_W'(seq);
        edge_and_settle();
    endtask

    task automatic do_exec(input int idx, input logic [31:0] addr);
        @(negedge clk);
        exec_valid = 1; exec_idx = IDX_W'(idx); exec_addr = addr;
        edge_and_settle();
    endtask

    // Store: expect either a fault with a given violator or no fault
    task automatic do_store(input int seq, input logic [31:0] addr, input bit exp_hit,
                            input int exp_idx, input int exp_seq, input string req);
        @(negedge clk);
        st_valid = 1; st_seq = SEQ_W'(seq); st_addr = addr;
        edge_and_settle();
        check(req, 32'(st_fault), 32'(exp_hit));
        if (exp_hit) begin
            exp_cnt++;
            check(req, 32'(viol_valid), 1);
            check(req, 32'(viol_idx), 32'(exp_idx));
            check(req, 32'(viol_seq), 32'(exp_seq));
        end
        check(req, 32'(viol_count), 32'(exp_cnt));
    endtask

    task automatic do_read(input int exp_idx, input string req);
        @(negedge clk);
        rd_viol = 1;
        #1;
        check(req, 32'(viol_valid), 1);
        check(req, 32'(viol_idx), 32'(exp_idx));
        edge_and_settle();
        check(req, 32'(viol_valid), 0);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check("R10 alloc_idx", 32'(alloc_idx), 0);
        check("R10 lq_full", 32'(lq_full), 0);
        check("R10 viol_valid", 32'(viol_valid), 0);
        check("R10 st_fault", 32'(st_fault), 0);
        check("R10 load_blocked", 32'(load_blocked), 0);
        check("R10 viol_count", 32'(viol_count), 0);
    endtask

    task automatic t_fill_and_exec();
        do_alloc(10, 0, "R1 first slot");
        do_alloc(11, 1, "R1 second slot");
        do_alloc(12, 2, "R1 third slot");
        do_exec(1, 32'h0000_1234);
        do_exec(2, 32'h0000_1280);
    endtask

    task automatic t_unexecuted();
        // slot 0 (seq 10) not executed; its address bits are zero
        do_store(10, 32'h0000_0010, 0, 0, 0, "R2 unexecuted load ignored");
    endtask

    task automatic t_region_miss();
        do_store(0, 32'h0000_1300, 0, 0, 0, "R3 other region");
    endtask

    task automatic t_conflict_and_hold();
        do_store(5, 32'h0000_12FF, 1, 1, 11, "R4 oldest younger match");
        do_store(5, 32'h0000_1200, 0, 0, 0, "R5 held skips search");
        check("R5 violator unchanged", 32'(viol_idx), 1);
        do_read(1, "R6 read and clear");
    endtask

    task automatic t_seq_edges();
        do_store(12, 32'h0000_1200, 1, 2, 12, "R3 equal sequence matches");
        do_read(2, "R6 read second");
        do_store(13, 32'h0000_1200, 0, 0, 0, "R3 older loads skipped");
    endtask

    task automatic t_same_cycle();
        do_store(0, 32'h0000_1200, 1, 1, 11, "R4 capture before collision");
        @(negedge clk);
        rd_viol = 1; st_valid = 1; st_seq = '0; st_addr = 32'h0000_1200;
        #1;
        check("R6 visible during read", 32'(viol_valid), 1);
        edge_and_settle();
        check("R6 cleared after read", 32'(viol_valid), 0);
        check("R6 store skipped no fault", 32'(st_fault), 0);
        check("R6 count unchanged", 32'(viol_count), 32'(exp_cnt));
        do_store(0, 32'h0000_1200, 1, 1, 11, "R6 next store captured");
        do_read(1, "R6 read after collision");
    endtask

    task automatic t_commit();
        @(negedge clk);
        commit_valid = 1; commit_seq = 16'd11;
        edge_and_settle();
        check("R7 freed slot reused", 32'(alloc_idx), 0);
        do_store(0, 32'h0000_1200, 1, 2, 12, "R7 committed loads gone");
        do_read(2, "R7 read");
    endtask

    task automatic t_squash_block();
        do_alloc(13, 0, "R1 slot after commit");
        do_alloc(14, 1, "R1 next slot");
        do_exec(0, 32'h0000_5000);
        do_exec(1, 32'h0000_5010);
        @(negedge clk);
        blk_set = 1; blk_seq = 16'd12;
        edge_and_settle();
        check("R9 blocked set", 32'(load_blocked), 1);
        @(negedge clk);
        squash_valid = 1; squash_seq = 16'd12;
        edge_and_settle();
        check("R9 squash not below keeps block", 32'(load_blocked), 1);
        check("R8 squashed slot free", 32'(alloc_idx), 0);
        do_store(0, 32'h0000_5000, 0, 0, 0, "R8 squashed loads gone");
        @(negedge clk);
        blk_set = 1; blk_seq = 16'd20;
        edge_and_settle();
        @(negedge clk);
        squash_valid = 1; squash_seq = 16'd15;
        edge_and_settle();
        check("R9 squash below clears block", 32'(load_blocked), 0);
    endtask

    task automatic t_full();
        // slot 2 still holds seq 12
        do_alloc(20, 0, "R1 fill");
        do_alloc(21, 1, "R1 fill");
        do_alloc(22, 3, "R1 skip busy slot");
        do_alloc(23, 4, "R1 fill");
        do_alloc(24, 5, "R1 fill");
        do_alloc(25, 6, "R1 fill");
        do_alloc(26, 7, "R1 fill last");
        check("R1 full", 32'(lq_full), 1);
        @(negedge clk);
        alloc_valid = 1; alloc_seq = 16'd27;
        edge_and_settle();
        check("R1 alloc while full ignored", 32'(lq_full), 1);
        @(negedge clk);
        commit_valid = 1; commit_seq = 16'd22;
        edge_and_settle();
        check("R7 commit frees oldest", 32'(alloc_idx), 0);
        check("R7 not full", 32'(lq_full), 0);
        @(negedge clk);
        commit_valid = 1; commit_seq = 16'hFFFF;
        edge_and_settle();
        do_alloc(30, 0, "R7 all retired");
        do_exec(0, 32'h0000_7000);
        do_store(30, 32'h0000_70AA, 1, 0, 30, "R4 after refill");
        do_read(0, "R6 final read");
    endtask

    initial begin
        t_reset();
        t_fill_and_exec();
        t_unexecuted();
        t_region_miss();
        t_conflict_and_hold();
        t_seq_edges();
        t_same_cycle();
        t_commit();
        t_squash_block();
        t_full();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule